// File: doc/BRIEF.md
# Synchronous Burst Address Generator

This block produces the word address for a synchronous burst memory. A full external address is captured on a rising clock edge whenever one of two address strobes is active. One is a processor strobe, which only counts while chip enable is high. The other is a controller strobe, which loads no matter what chip enable is doing. Once an address has been captured, an advance input steps the two least significant address bits through a four-word group. The upper bits stay frozen.

The order in which the low bits are stepped is fixed when the burst is loaded, from an order-select input. In linear order the start offset is incremented modulo four. In interleaved order the start offset is XORed with a rising two-bit count. Bursts are optional: a new address may be strobed in on every cycle, and each one appears at the output on the next cycle with no dead cycle between them. The output is the current address plus a flag that goes high at the first load and stays high.

Top module: `burst_addr_gen`

## Requirements
- R1: During and after an active-low reset with no strobe, `addrValid` is 0 and `addrOut` is all zeros.
- R2: When `cpuStrobe` is 1 and `chipEn` is 1 at a rising edge, `addrOut` equals `addrIn` from that edge and `addrValid` is 1 after the edge.
- R3: When `ctlStrobe` is 1 at a rising edge, `addrIn` is loaded in the same way whatever the level of `chipEn`.
- R4: When `cpuStrobe` is 1, `chipEn` is 0 and `ctlStrobe` is 0, nothing is loaded. `addrOut` and `addrValid` keep their previous values, unless `advance` steps them as in R5.
- R5: When no strobe loads and `advance` is 1 while `addrValid` is 1, the burst count goes up by one. When `advance` is 0, `addrOut` holds.
- R6: With `orderSel` = 0 at the load edge (linear order), `addrOut[1:0]` after n advances is (start + n) mod 4.
- R7: With `orderSel` = 1 at the load edge (interleaved order), `addrOut[1:0]` after n advances is start XOR (n mod 4).
- R8: During a burst, `addrOut[ADDR_W-1:2]` never changes. After four advances, the low bits return to the start offset.
- R9: A strobe that loads in the same cycle as `advance` wins: the new address is taken and the count restarts at zero.
- R10: Strobes on consecutive cycles each load, and each address appears on the cycle right after its strobe.
- R11: `advance` before the first load has no effect: `addrOut` stays zero and `addrValid` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| chipEn | input | 1 | Qualifies the processor strobe |
| cpuStrobe | input | 1 | Processor address strobe, gated by chipEn |
| ctlStrobe | input | 1 | Controller address strobe, ungated |
| advance | input | 1 | Steps the burst count |
| orderSel | input | 1 | 0 = linear order, 1 = interleaved order, taken at load |
| addrIn | input | ADDR_W | External address |
| addrOut | output | ADDR_W | Current word address |
| addrValid | output | 1 | High once any address has been loaded |

## Verification
Wrap-around is the main target. A counter that carried into bit 2 would corrupt the upper address on the fourth linear advance. A counter that used addition in interleaved mode would produce the wrong sequence from an odd start offset. The bench also drives strobe and advance together: a design that let advance win would show the old address plus one instead of the new address. Chip enable is toggled against each strobe, so a gate on the wrong strobe shows up as a load that is missing or one that should not happen. Back-to-back loads and advance before the first load round out the cases.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  typedef struct packed {
    logic load;
    logic step;
  } ctlStrobes_t;
endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_addr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        chipEn,
  input  logic        cpuStrobe,
  input  logic        ctlStrobe,
  input  logic        advance,
  output ctlStrobes_t strb,
  output logic        valid
);
  logic loadNow;

  assign loadNow   = ctlStrobe | (cpuStrobe & chipEn);
  assign strb.load = loadNow;
  assign strb.step = advance & valid & ~loadNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        valid <= 1'b0;
    else if (loadNow) valid <= 1'b1;
  end

  // R2: once set, valid never drops outside reset
  a_r2_valid_sticky: assert property (@(posedge clk) disable iff (!rstN)
    valid |=> valid);

  // R4: a gated processor strobe alone never leaves valid set
  a_r4_gated_cpu: assert property (@(posedge clk) disable iff (!rstN)
    (!valid && !chipEn && !ctlStrobe) |=> !valid);
endmodule

// File: rtl/burst_datapath.sv
module burst_datapath
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strb,
  input  logic              orderSel,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] addrOut
);
  localparam int UPPER_W = ADDR_W - 2;

  logic [UPPER_W-1:0] baseHi;
  logic [1:0]         baseLo;
  logic [1:0]         count;
  logic               ilvMode;
  logic [1:0]         curLo;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseHi  <= '0;
      baseLo  <= '0;
      count   <= '0;
      ilvMode <= 1'b0;
    end else if (strb.load) begin
      baseHi  <= addrIn[ADDR_W-1:2];
      baseLo  <= addrIn[1:0];
      count   <= '0;
      ilvMode <= orderSel;
    end else if (strb.step) begin
      count <= count + 2'd1;
    end
  end

  always_comb begin
    if (ilvMode) curLo = baseLo ^ count;
    else         curLo = baseLo + count;
  end

  assign addrOut = {baseHi, curLo};

  // R2, R3, R9: a load shows the captured address on the next cycle
  a_r9_load_wins: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> addrOut == $past(addrIn));

  // R8: upper bits move only on a load
  a_r8_upper_fixed: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(addrOut[ADDR_W-1:2]));

  // R5: no load and no step means the address holds
  a_r5_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && !strb.step) |=> $stable(addrOut));

  // R6: a linear step adds one to the low bits modulo four
  a_r6_linear_step: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && !ilvMode) |=> addrOut[1:0] == $past(addrOut[1:0]) + 2'd1);
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipEn,
  input  logic              cpuStrobe,
  input  logic              ctlStrobe,
  input  logic              advance,
  input  logic              orderSel,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] addrOut,
  output logic              addrValid
);
  ctlStrobes_t strb;

  burst_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .chipEn    (chipEn),
    .cpuStrobe (cpuStrobe),
    .ctlStrobe (ctlStrobe),
    .advance   (advance),
    .strb      (strb),
    .valid     (addrValid)
  );

  burst_datapath #(.ADDR_W(ADDR_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .orderSel (orderSel),
    .addrIn   (addrIn),
    .addrOut  (addrOut)
  );
endmodule

// File: tb/burst_addr_gen_tb_top.sv
module burst_addr_gen_tb_top;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          chipEn = 1'b0, cpuStrobe = 1'b0, ctlStrobe = 1'b0;
  logic          advance = 1'b0, orderSel = 1'b0;
  logic [AW-1:0] addrIn = '0;
  logic [AW-1:0] addrOut;
  logic          addrValid;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // behavioural reference state
  int mBase = 0;
  int mCnt = 0;
  bit mIlv = 0;
  bit mValid = 0;

  always #4 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .chipEn(chipEn), .cpuStrobe(cpuStrobe),
    .ctlStrobe(ctlStrobe), .advance(advance), .orderSel(orderSel),
    .addrIn(addrIn), .addrOut(addrOut), .addrValid(addrValid)
  );

  function automatic int modelAddr();
    int lo;
    int start = mBase % 4;
    if (mIlv) lo = start ^ (mCnt % 4);
    else      lo = (start + mCnt) % 4;
    return (mBase - start) + lo;
  endfunction

  task automatic check(string req);
    int exp = modelAddr();
    compared++;
    if (addrOut !== exp[AW-1:0] || addrValid !== mValid) begin
      mismatched++;
      $display("FAIL %s: addr=%h valid=%b expected addr=%h valid=%b",
               req, addrOut, addrValid, exp[AW-1:0], mValid);
    end
  endtask

  // apply inputs, take one edge, update model, check away from the edge
  task automatic cyc(string req, bit ce, bit cs, bit ks, bit adv, bit ord, int a);
    bit ld;
    chipEn = ce; cpuStrobe = cs; ctlStrobe = ks; advance = adv;
    orderSel = ord; addrIn = a[AW-1:0];
    @(posedge clk);
    ld = ks || (cs && ce);
    if (ld) begin
      mBase = a; mCnt = 0; mIlv = ord; mValid = 1;
    end else if (adv && mValid) begin
      mCnt++;
    end
    @(negedge clk);
    check(req);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: expected run end, got hang");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1");
    rstN = 1'b1;
    @(negedge clk);
    check("R1");
    // R11: advance before any load
    cyc("R11", 1, 0, 0, 1, 0, 0);
    cyc("R11", 1, 0, 0, 1, 1, 0);
    // R4: gated processor strobe
    cyc("R4", 0, 1, 0, 0, 0, 'h12345);
    // R2: processor strobe with chip enable, linear from offset 2
    cyc("R2", 1, 1, 0, 0, 0, 'hABCD6);
    // R6/R8: linear wrap
    for (int i = 0; i < 4; i++) cyc("R6", 1, 0, 0, 1, 1, 'h0);
    cyc("R8", 1, 0, 0, 0, 0, 'h0);
    // R5: hold without advance
    cyc("R5", 1, 0, 0, 0, 0, 'h0);
    // R3: controller strobe with chip enable low, interleaved from offset 1
    cyc("R3", 0, 0, 1, 0, 1, 'h55551);
    for (int i = 0; i < 5; i++) cyc("R7", 0, 0, 0, 1, 0, 'h0);
    // R7: interleaved from offset 3
    cyc("R3", 1, 0, 1, 0, 1, 'h0F0F3);
    for (int i = 0; i < 4; i++) cyc("R7", 1, 0, 0, 1, 0, 'h0);
    // R4: gated processor strobe mid-burst, with advance
    cyc("R4", 0, 1, 0, 1, 0, 'h77777);
    // R9: strobe together with advance
    cyc("R9", 1, 1, 0, 1, 0, 'h12343);
    cyc("R9", 1, 0, 1, 1, 1, 'h22222);
    cyc("R9", 1, 0, 0, 1, 1, 'h0);
    // R10: a new load every cycle
    for (int i = 0; i < 8; i++) cyc("R10", 1, 1, 0, 0, i[0], 'h10000 + i * 'h111);
    // R10: mixed random traffic
    for (int i = 0; i < 400; i++)
      cyc("R10", 1'($urandom), 1'($urandom), 1'($urandom % 4 == 0),
          1'($urandom), 1'($urandom), int'($urandom % (1 << AW)));
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule